// File: doc/BRIEF.md
# Three-Phase Bridge Fault Supervisor

This block watches over a three-phase half-bridge power stage. It receives the digital outputs of three kinds of outside comparators: an overcurrent flag, a flag that the logic supply has dropped too low, and one flag per phase that the bootstrap supply of that phase's upper switch has sagged. It also observes all six gate commands: an upper and a lower command per phase, each active low. From these it produces a force-off line for the gate logic, a per-phase upper-switch disable and an active-low fault line that models an open-drain pin.

Every switching event opens a short blanking window. During that window the overcurrent flag is disregarded, so that transients caused by switching do not shut the bridge down. An overcurrent seen outside that window is latched. The latch turns all six switches off and pulls the fault line low. The latch clears only after the overcurrent flag has gone away and all three lower commands have stayed inactive without a break for a full release window. A logic-supply undervoltage shuts everything off only while it lasts. A bootstrap-supply undervoltage removes only the upper switch of its own phase and does not touch the fault line.

Timing windows are given in nanoseconds and microseconds and are turned into clock counts from the `CLK_HZ` parameter. The defaults give 10 cycles of blanking and 1000 cycles of release at 100 MHz. There is no data stream; every pin is a plain level signal.

Top module: `bridge_fault_sup`

## Requirements
- R1: Every input passes a two-flop synchronizer. A change on the logic-undervoltage or bootstrap-undervoltage flags reaches the outputs after exactly two rising clock edges.
- R2: While `rst_n` is low and right after reset: `force_off_o`=0, `hs_off_o`=3'b000 and `fault_n_o`=1. The commands reset to inactive (1) and the flags reset to inactive (0).
- R3: A change on any of the six synchronized commands starts a blanking window. The window covers the cycle of the change plus BLANK_CYC = ceil(BLANK_NS*CLK_HZ/1e9) further cycles. A synchronized overcurrent flag inside the window does not set the latch.
- R4: A synchronized overcurrent flag outside blanking sets the latch on the next edge, that is three edges after the input. While the latch is set, `force_off_o`=1, `hs_off_o`=3'b111 and `fault_n_o`=0.
- R5: The latch clears after REL_CYC = ceil(RELEASE_US*CLK_HZ/1e6) consecutive cycles in which the synchronized overcurrent flag is 0 and all three lower commands are 1 (inactive). The outputs are released on the edge that ends the last of those cycles.
- R6: Any cycle inside the release window in which a lower command is 0 (active) or the overcurrent flag is 1 restarts the count from zero.
- R7: While the synchronized logic-undervoltage flag is 1, `force_off_o`=1, `hs_off_o`=3'b111 and `fault_n_o`=0. The outputs return to normal as soon as the flag is 0, with no latching.
- R8: A bootstrap-undervoltage flag on phase p (bit p) sets only `hs_off_o[p]`. It has no effect on `force_off_o` or `fault_n_o`.
- R9: `fault_n_o` is 0 exactly when `force_off_o` is 1 and 1 otherwise. 0 means the pin is pulled down and 1 means it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oc_flag_i | input | 1 | Overcurrent comparator output, 1 = overcurrent |
| vlogic_uv_i | input | 1 | Logic-supply undervoltage, 1 = too low |
| boot_uv_i | input | 3 | Per-phase bootstrap undervoltage, 1 = too low |
| hi_cmd_n_i | input | 3 | Upper-switch commands, 0 = on |
| lo_cmd_n_i | input | 3 | Lower-switch commands, 0 = on |
| force_off_o | output | 1 | Turn all six switches off |
| hs_off_o | output | 3 | Per-phase upper-switch disable |
| fault_n_o | output | 1 | Open-drain style fault, 0 = pulled low |

## Verification
Two functions can fall in the same cycle. A command edge can meet an overcurrent flag, which is a contest between blanking and latching. A lower command can go active inside a release window, which is a contest between the restart and the clear. The bench provokes the first by toggling a command on the same cycle an overcurrent pulse starts, and then again just after the window closes. It provokes the second by pulsing a lower command part way through the release count. A cycle-level bench model, built from the requirements, decides on every cycle whether the latch should be set and when it should drop.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  // ceiling of (amount * clk_hz / scale), never below one
  function automatic int unsigned cycles_for(input longint unsigned amount,
                                             input longint unsigned clk_hz,
                                             input longint unsigned scale);
    longint unsigned prod;
    longint unsigned res;
    prod = amount * clk_hz;
    res  = (prod + scale - 1) / scale;
    if (res == 0) res = 1;
    return int'(res);
  endfunction
endpackage

// File: rtl/bfs_sync.sv
module bfs_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bfs_blank.sv
module bfs_blank #(
  parameter int NCMD      = 6,
  parameter int BLANK_CYC = 10,
  localparam int CW       = $clog2(BLANK_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMD-1:0] cmd_i,
  input  logic            oc_i,
  output logic            blank_o,
  output logic            oc_valid_o
);
  logic [NCMD-1:0] cmd_q;
  logic [CW-1:0]   cnt_q;
  logic            sw_edge;

  assign sw_edge = |(cmd_i ^ cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '1;
      cnt_q <= '0;
    end else begin
      cmd_q <= cmd_i;
      if (sw_edge)
        cnt_q <= CW'(BLANK_CYC);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign blank_o    = sw_edge || (cnt_q != '0);
  assign oc_valid_o = oc_i && !blank_o;
endmodule

// File: rtl/bfs_oc_latch.sv
module bfs_oc_latch #(
  parameter int REL_CYC = 1000,
  localparam int RW     = $clog2(REL_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_valid_i,
  input  logic oc_i,
  input  logic lo_idle_i,
  output logic latched_o
);
  logic          lat_q;
  logic [RW-1:0] rel_q;
  logic          qualify;

  assign qualify = !oc_i && lo_idle_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      rel_q <= '0;
    end else if (oc_valid_i) begin
      lat_q <= 1'b1;
      rel_q <= '0;
    end else if (lat_q) begin
      if (!qualify) begin
        rel_q <= '0;
      end else if (rel_q == RW'(REL_CYC - 1)) begin
        lat_q <= 1'b0;
        rel_q <= '0;
      end else begin
        rel_q <= rel_q + 1'b1;
      end
    end else begin
      rel_q <= '0;
    end
  end

  assign latched_o = lat_q;
endmodule

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup #(
  parameter longint unsigned CLK_HZ     = 100_000_000,
  parameter int              BLANK_NS   = 100,
  parameter int              RELEASE_US = 10,
  parameter int              SYNC_STAGES = 2,
  parameter int              PH         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oc_flag_i,
  input  logic          vlogic_uv_i,
  input  logic [PH-1:0] boot_uv_i,
  input  logic [PH-1:0] hi_cmd_n_i,
  input  logic [PH-1:0] lo_cmd_n_i,
  output logic          force_off_o,
  output logic [PH-1:0] hs_off_o,
  output logic          fault_n_o
);
  import bfs_pkg::*;

  localparam int BLANK_CYC = cycles_for(longint'(BLANK_NS), CLK_HZ, 64'd1_000_000_000);
  localparam int REL_CYC   = cycles_for(longint'(RELEASE_US), CLK_HZ, 64'd1_000_000);
  localparam int SW        = 3 * PH + 2;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, {PH{1'b0}}, {PH{1'b1}}, {PH{1'b1}}};

  logic [SW-1:0] raw_in;
  logic [SW-1:0] syn;
  logic          s_oc;
  logic          s_uv;
  logic [PH-1:0] s_hsuv;
  logic [PH-1:0] s_hi_n;
  logic [PH-1:0] s_lo_n;
  logic          lo_idle;
  logic          blank_active;
  logic          oc_valid;
  logic          oc_lat;
  logic          force_off;

  assign raw_in = {oc_flag_i, vlogic_uv_i, boot_uv_i, hi_cmd_n_i, lo_cmd_n_i};

  bfs_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn)
  );

  assign {s_oc, s_uv, s_hsuv, s_hi_n, s_lo_n} = syn;
  assign lo_idle = &s_lo_n;

  bfs_blank #(.NCMD(2 * PH), .BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .cmd_i({s_hi_n, s_lo_n}), .oc_i(s_oc),
    .blank_o(blank_active), .oc_valid_o(oc_valid)
  );

  bfs_oc_latch #(.REL_CYC(REL_CYC)) u_latch (
    .clk(clk), .rst_n(rst_n), .oc_valid_i(oc_valid), .oc_i(s_oc),
    .lo_idle_i(lo_idle), .latched_o(oc_lat)
  );

  assign force_off   = oc_lat || s_uv;
  assign force_off_o = force_off;
  assign fault_n_o   = !force_off;

  generate
    for (genvar p = 0; p < PH; p++) begin : g_phase
      assign hs_off_o[p] = force_off || s_hsuv[p];
    end
  endgenerate
endmodule

// File: rtl/bridge_fault_sup_chk.sv
module bridge_fault_sup_chk #(
  parameter int PH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_oc,
  input logic          s_uv,
  input logic [PH-1:0] s_hsuv,
  input logic          lo_idle,
  input logic          blank_active,
  input logic          oc_lat,
  input logic          force_off_o,
  input logic [PH-1:0] hs_off_o,
  input logic          fault_n_o
);
  // R3
  blank_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_active |=> !$rose(oc_lat));

  // R4
  trip_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_lat) |-> $past(s_oc));

  // R4
  latch_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_lat |-> (force_off_o && (&hs_off_o) && !fault_n_o));

  // R5
  clear_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_lat) |-> ($past(lo_idle) && !$past(s_oc)));

  // R6
  active_low_side_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lat && !lo_idle) |=> oc_lat);

  // R7
  uv_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_uv |-> (force_off_o && !fault_n_o));

  // R8
  hs_uv_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_lat && !s_uv && (|s_hsuv)) |-> (fault_n_o && !force_off_o && ((hs_off_o & s_hsuv) == s_hsuv)));

  // R9
  fault_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n_o != force_off_o);
endmodule

bind bridge_fault_sup bridge_fault_sup_chk #(.PH(PH)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_oc(s_oc), .s_uv(s_uv), .s_hsuv(s_hsuv),
  .lo_idle(lo_idle), .blank_active(blank_active), .oc_lat(oc_lat),
  .force_off_o(force_off_o), .hs_off_o(hs_off_o), .fault_n_o(fault_n_o)
);

// File: tb/bridge_fault_sup_tb.sv
module bridge_fault_sup_tb;
  localparam int BLANK = 10;   // 100 ns at 100 MHz
  localparam int REL   = 1000; // 10 us at 100 MHz

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc = 1'b0, uv = 1'b0;
  logic [2:0] buv = 3'b000, hin = 3'b111, lon = 3'b111;
  logic force_off;
  logic [2:0] hs_off;
  logic fault_n;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bridge_fault_sup u_dut (
    .clk(clk), .rst_n(rst_n), .oc_flag_i(oc), .vlogic_uv_i(uv),
    .boot_uv_i(buv), .hi_cmd_n_i(hin), .lo_cmd_n_i(lon),
    .force_off_o(force_off), .hs_off_o(hs_off), .fault_n_o(fault_n)
  );

  // cycle model built from the requirements
  logic       m1_oc, m2_oc, m1_uv, m2_uv;
  logic [2:0] m1_b, m2_b, m1_h, m2_h, m1_l, m2_l;
  logic [5:0] m_prev;
  int         m_bc, m_rc;
  logic       m_lat;

  function automatic logic exp_force(input logic lat, input logic suv);
    return lat | suv;
  endfunction

  function automatic logic [2:0] exp_hs(input logic f, input logic [2:0] b);
    return {3{f}} | b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_oc <= 0; m2_oc <= 0; m1_uv <= 0; m2_uv <= 0;
      m1_b <= 0; m2_b <= 0; m1_h <= '1; m2_h <= '1; m1_l <= '1; m2_l <= '1;
      m_prev <= '1; m_bc <= 0; m_rc <= 0; m_lat <= 0;
    end else begin
      logic edge_now, blanked;
      m1_oc <= oc; m2_oc <= m1_oc; m1_uv <= uv; m2_uv <= m1_uv;
      m1_b <= buv; m2_b <= m1_b; m1_h <= hin; m2_h <= m1_h; m1_l <= lon; m2_l <= m1_l;
      edge_now = ({m2_h, m2_l} != m_prev);
      blanked  = edge_now || (m_bc != 0);
      m_prev <= {m2_h, m2_l};
      if (edge_now) m_bc <= BLANK; else if (m_bc != 0) m_bc <= m_bc - 1;
      if (m2_oc && !blanked) begin
        m_lat <= 1; m_rc <= 0;
      end else if (m_lat) begin
        if (m2_oc || (m2_l != 3'b111)) m_rc <= 0;
        else if (m_rc == REL - 1) begin m_lat <= 0; m_rc <= 0; end
        else m_rc <= m_rc + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // compare outputs against the model, then advance one cycle
  task automatic step();
    logic ef;
    @(negedge clk);
    cyc++;
    ef = exp_force(m_lat, m2_uv);
    chk(force_off == ef, "R4/R7 force_off", force_off, ef);
    chk(hs_off == exp_hs(ef, m2_b), "R8 hs_off", hs_off, exp_hs(ef, m2_b));
    chk(fault_n == !ef, "R9 fault_n", fault_n, !ef);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(force_off == 0 && hs_off == 0 && fault_n == 1, "R2 reset",
        {force_off, hs_off, fault_n}, 4'b0001);
    rst_n = 1'b1;
    run(4);

    // R1 / R7: logic UV visible after exactly two edges, auto release
    uv = 1; step();
    chk(force_off == 0, "R1 uv after one edge", force_off, 0);
    step();
    chk(force_off == 1 && fault_n == 0, "R7 uv forces", {force_off, fault_n}, 2'b10);
    run(5);
    uv = 0; run(2);
    chk(force_off == 0 && fault_n == 1, "R7 uv release", {force_off, fault_n}, 2'b01);

    // R8: bootstrap UV on phase 1 only
    buv = 3'b010; run(3);
    chk(hs_off == 3'b010 && fault_n == 1 && force_off == 0, "R8 phase only",
        {hs_off, fault_n}, 4'b0101);
    buv = 3'b000; run(3);

    // R3: overcurrent pulse coinciding with a command edge is blanked
    hin = 3'b110; oc = 1; run(6);
    oc = 0; run(4);
    chk(force_off == 0, "R3 blanked pulse", force_off, 0);
    hin = 3'b111; run(30);

    // R4: overcurrent far from switching trips after three edges
    oc = 1; run(2);
    chk(force_off == 0, "R4 not yet", force_off, 0);
    step();
    chk(force_off == 1 && hs_off == 3'b111 && fault_n == 0, "R4 trip",
        {force_off, hs_off, fault_n}, 5'b11110);
    oc = 0;
    // R6: low-side command mid-window restarts count
    run(500);
    lon = 3'b011; run(3); lon = 3'b111;
    run(REL - 10);
    chk(force_off == 1, "R6 restart holds latch", force_off, 1);
    // R5: clears after the full quiet window
    run(40);
    chk(force_off == 0 && fault_n == 1, "R5 latch released", {force_off, fault_n}, 2'b01);

    // R3 boundary: pulse just after the window closes does trip
    lon = 3'b110; step(); lon = 3'b111; run(BLANK + 4);
    oc = 1; run(4); oc = 0;
    chk(force_off == 1, "R3 after window trips", force_off, 1);
    run(REL + 20);
    chk(force_off == 0, "R5 second release", force_off, 0);

    // mixed random traffic checked by the model every cycle
    for (int blk = 0; blk < 40; blk++) begin
      int mode = $urandom % 4;
      int len  = 50 + ($urandom % 1200);
      for (int i = 0; i < len; i++) begin
        case (mode)
          0: begin oc = ($urandom % 64) == 0; lon = '1; hin = '1; end
          1: begin hin = 3'($urandom); lon = (($urandom % 8) == 0) ? 3'($urandom) : lon;
                   oc = ($urandom % 16) == 0; end
          2: begin uv = ($urandom % 32) == 0 ? ~uv : uv; buv = 3'($urandom % 8 == 0 ? $urandom : buv); end
          default: begin oc = 0; lon = ($urandom % 200) == 0 ? 3'b101 : 3'b111; end
        endcase
        step();
      end
    end
    oc = 0; uv = 0; buv = 0; lon = '1; hin = '1;
    run(REL + 20);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule